// File: doc/BRIEF.md
# Strobed Control-Register Receiver with Routing Table

This block sits on the device side of a narrow control link that a host drives through one general-purpose output word. The lower seven bits of that word form a shared lane. The top bit is a strobe. On each rising edge of the strobe the receiver takes the lane. A lane code with bit 6 set is an address phase and selects one of 64 six-bit registers. A lane code with bit 6 clear is a data phase and stores its six-bit value into the register just selected. The word the host reads back carries the contents of the selected register. Its top bit serves as an interrupt line that pulses when the read bits change.

Four of the registers program a destination-to-source routing table. The host writes a destination (high part, then low part) and a source (high part, then low part). Writing the low part of the source commits the link. Once the destination registers are set, reading the two source registers returns the link currently stored for that destination. A separate lookup port lets neighbouring logic read the table.

Top module: `gpio_strobe_port`

## Requirements
- R1: After reset, every register holds 0, every routing entry holds source 0, and `host_in_o` reads 0.
- R2: A rising edge of `lane_i[7]` with `lane_i[6]`=1 selects register `lane_i[5:0]`. Within a few cycles, `host_in_o[6:0]` shows that register's contents.
- R3: A rising edge of `lane_i[7]` with `lane_i[6]`=0, directly after an address phase, writes `lane_i[5:0]` into the selected register.
- R4: A data phase is ignored when no address phase precedes it. This covers a data phase straight after reset and a second data phase after a write.
- R5: Changing the lane while `lane_i[7]` stays high has no effect, because only a low-to-high transition of bit 7 takes the lane.
- R6: With `wide_rd_i`=1, `host_in_o[6:0]` passes the full value. With `wide_rd_i`=0 it keeps only bits 4:0, and bits 6:5 read 0.
- R7: `host_in_o[7]` is high for exactly one cycle each time `host_in_o[6:0]` changes, and is low otherwise.
- R8: Writing register 0x33 (source-low) commits a routing entry. The entry index is `dsthi[2:0]*32 + dstlo[4:0]`, taken from registers 0x30 and 0x31. The stored source is `srchi[2:0]*32 + value[4:0]`, with source-high taken from register 0x32. Register bits above these fields are dropped.
- R9: While register 0x32 or 0x33 is selected, the read word returns bits 7:5 or bits 4:0 of the routing entry for the destination held in registers 0x30 and 0x31.
- R10: Each destination holds exactly one source, so a later commit replaces the earlier one. The same source may be stored at any number of destinations.
- R11: `lk_src_o` returns the routing entry for destination `lk_dst_i`, encoded as source-high*32 + source-low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lane_i | input | 8 | Host output word: bit 7 strobe, bit 6 address flag, bits 5:0 value |
| wide_rd_i | input | 1 | 1 = return 7 read bits, 0 = return 5 read bits |
| host_in_o | output | 8 | Read word: bit 7 interrupt pulse, bits 6:0 masked register contents |
| lk_dst_i | input | 8 | Destination index for the routing lookup |
| lk_src_o | output | 8 | Source stored for `lk_dst_i` |

## Verification
The bench sweeps every register, and then every routing destination, with arithmetically generated values. A wrong address offset or a dropped write therefore shows up as a specific mismatched register or entry.

It also goes after the protocol corners:
- A data phase with no address phase in front of it. A design that failed to clear its pending flag would overwrite the last register.
- A lane change while the strobe stays high. A level-sensitive design would take that change as a write.
- The commit point, which must fall on the source-low write only. A design that committed early would store half-built links.
- Many destinations sharing one source, followed by an overwrite. This exposes a table that indexes or clears the wrong entry.
- The interrupt pulse count and the narrow read mask. These catch an interrupt that is sticky or missed, and a mask that leaks bit 5.

// File: rtl/gpcp_pkg.sv
package gpcp_pkg;
   // Source of the value shown on the read word
   typedef enum logic [1:0] {
      RD_BANK     = 2'd0,
      RD_ROUTE_HI = 2'd1,
      RD_ROUTE_LO = 2'd2
   } rd_sel_e;
endpackage

// File: rtl/gpcp_lane_sync.sv
module gpcp_lane_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lane_i,
   output logic [W-1:0] lane_o,
   output logic         rise_o
);
   logic [STAGES-1:0][W-1:0] stg;
   logic                     strobe_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg         <= '0;
         strobe_prev <= 1'b0;
      end else begin
         stg         <= {stg[STAGES-2:0], lane_i};
         strobe_prev <= stg[STAGES-1][W-1];
      end
   end

   assign lane_o = stg[STAGES-1];
   assign rise_o = stg[STAGES-1][W-1] & ~strobe_prev;
endmodule

// File: rtl/gpcp_phase_decoder.sv
module gpcp_phase_decoder #(
   parameter int VW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise_i,
   input  logic [VW:0]   code_i,
   output logic          addr_ld_o,
   output logic          wr_en_o,
   output logic [VW-1:0] wdata_o,
   output logic [VW-1:0] ptr_o,
   output logic          pend_o
);
   always_comb begin
      addr_ld_o = rise_i &  code_i[VW];
      wr_en_o   = rise_i & ~code_i[VW] & pend_o;
      wdata_o   = code_i[VW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o  <= '0;
         pend_o <= 1'b0;
      end else if (addr_ld_o) begin
         ptr_o  <= code_i[VW-1:0];
         pend_o <= 1'b1;
      end else if (wr_en_o) begin
         pend_o <= 1'b0;
      end
   end
endmodule

// File: rtl/gpcp_reg_bank.sv
module gpcp_reg_bank #(
   parameter int VW     = 6,
   parameter int TAP_A  = 48,
   parameter int TAP_B  = 49,
   parameter int TAP_C  = 50,
   localparam int DEPTH = 1 << VW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [VW-1:0] waddr_i,
   input  logic [VW-1:0] wdata_i,
   input  logic [VW-1:0] raddr_i,
   output logic [VW-1:0] rdata_o,
   output logic [VW-1:0] tap_a_o,
   output logic [VW-1:0] tap_b_o,
   output logic [VW-1:0] tap_c_o
);
   logic [VW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en_i) begin
         mem[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem[raddr_i];
   assign tap_a_o = mem[TAP_A];
   assign tap_b_o = mem[TAP_B];
   assign tap_c_o = mem[TAP_C];
endmodule

// File: rtl/gpcp_route_table.sv
module gpcp_route_table #(
   parameter int HI_W     = 3,
   parameter int LO_W     = 5,
   localparam int IDX_W   = HI_W + LO_W,
   localparam int ENTRIES = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [IDX_W-1:0] wr_src_i,
   input  logic [IDX_W-1:0] rd_a_idx_i,
   output logic [IDX_W-1:0] rd_a_src_o,
   input  logic [IDX_W-1:0] rd_b_idx_i,
   output logic [IDX_W-1:0] rd_b_src_o
);
   logic [IDX_W-1:0] ent [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
      end else if (commit_i) begin
         ent[wr_idx_i] <= wr_src_i;
      end
   end

   assign rd_a_src_o = ent[rd_a_idx_i];
   assign rd_b_src_o = ent[rd_b_idx_i];
endmodule

// File: rtl/gpio_strobe_port.sv
module gpio_strobe_port
   import gpcp_pkg::*;
#(
   parameter int CODE_W      = 6,
   parameter int HI_W        = 3,
   parameter int LO_W        = 5,
   parameter int SYNC_STAGES = 2,
   parameter int REG_DST_HI  = 48,
   parameter int REG_DST_LO  = 49,
   parameter int REG_SRC_HI  = 50,
   parameter int REG_SRC_LO  = 51,
   localparam int LANE_W     = CODE_W + 2,
   localparam int IDX_W      = HI_W + LO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANE_W-1:0] lane_i,
   input  logic              wide_rd_i,
   output logic [LANE_W-1:0] host_in_o,
   input  logic [IDX_W-1:0]  lk_dst_i,
   output logic [IDX_W-1:0]  lk_src_o
);
   localparam int RD_W = CODE_W + 1;
   localparam logic [CODE_W-1:0] A_SRC_HI = CODE_W'(REG_SRC_HI);
   localparam logic [CODE_W-1:0] A_SRC_LO = CODE_W'(REG_SRC_LO);
   localparam logic [RD_W-1:0]   MASK_NARROW = RD_W'((1 << LO_W) - 1);
   localparam logic [RD_W-1:0]   MASK_WIDE   = {RD_W{1'b1}};

   // Elaboration-time parameter checks
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (HI_W > CODE_W || LO_W > CODE_W) begin : g_bad_field
         $error("routing fields wider than a register value");
      end
      if (IDX_W > 10) begin : g_bad_idx
         $error("routing table too large");
      end
      if (REG_SRC_LO >= (1 << CODE_W) || REG_SRC_HI >= (1 << CODE_W) ||
          REG_DST_HI >= (1 << CODE_W) || REG_DST_LO >= (1 << CODE_W)) begin : g_bad_addr
         $error("routing register address out of range");
      end
   endgenerate

   logic [LANE_W-1:0] lane_s;
   logic              rise;
   logic              addr_ld, wr_en, pend;
   logic [CODE_W-1:0] wdata, ptr, bank_rd;
   logic [CODE_W-1:0] dst_hi, dst_lo, src_hi;
   logic              commit;
   logic [IDX_W-1:0]  cur_idx, cur_src, wr_src;
   rd_sel_e           rd_sel;
   logic [CODE_W-1:0] rd_val;
   logic [RD_W-1:0]   rd_masked, rd_q;
   logic              irq_q;

   gpcp_lane_sync #(.W(LANE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .lane_i (lane_i),
      .lane_o (lane_s),
      .rise_o (rise)
   );

   gpcp_phase_decoder #(.VW(CODE_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise),
      .code_i    (lane_s[CODE_W:0]),
      .addr_ld_o (addr_ld),
      .wr_en_o   (wr_en),
      .wdata_o   (wdata),
      .ptr_o     (ptr),
      .pend_o    (pend)
   );

   gpcp_reg_bank #(
      .VW(CODE_W), .TAP_A(REG_DST_HI), .TAP_B(REG_DST_LO), .TAP_C(REG_SRC_HI)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en),
      .waddr_i (ptr),
      .wdata_i (wdata),
      .raddr_i (ptr),
      .rdata_o (bank_rd),
      .tap_a_o (dst_hi),
      .tap_b_o (dst_lo),
      .tap_c_o (src_hi)
   );

   assign commit  = wr_en && (ptr == A_SRC_LO);
   assign cur_idx = {dst_hi[HI_W-1:0], dst_lo[LO_W-1:0]};
   assign wr_src  = {src_hi[HI_W-1:0], wdata[LO_W-1:0]};

   gpcp_route_table #(.HI_W(HI_W), .LO_W(LO_W)) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .wr_idx_i   (cur_idx),
      .wr_src_i   (wr_src),
      .rd_a_idx_i (cur_idx),
      .rd_a_src_o (cur_src),
      .rd_b_idx_i (lk_dst_i),
      .rd_b_src_o (lk_src_o)
   );

   always_comb begin
      if (ptr == A_SRC_HI)      rd_sel = RD_ROUTE_HI;
      else if (ptr == A_SRC_LO) rd_sel = RD_ROUTE_LO;
      else                      rd_sel = RD_BANK;
      case (rd_sel)
         RD_ROUTE_HI: rd_val = CODE_W'(cur_src[IDX_W-1:LO_W]);
         RD_ROUTE_LO: rd_val = CODE_W'(cur_src[LO_W-1:0]);
         default:     rd_val = bank_rd;
      endcase
      rd_masked = {1'b0, rd_val} & (wide_rd_i ? MASK_WIDE : MASK_NARROW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         rd_q  <= rd_masked;
         irq_q <= (rd_masked != rd_q);
      end
   end

   assign host_in_o = {irq_q, rd_q};
endmodule

// File: rtl/gpcp_checker.sv
module gpcp_checker #(
   parameter int HW   = 8,
   parameter int LO_W = 5,
   parameter int IW   = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wide_rd_i,
   input logic [HW-1:0] host_in_o,
   input logic [IW-1:0] lk_dst_i,
   input logic [IW-1:0] lk_src_o,
   input logic          addr_ld,
   input logic          wr_en,
   input logic          pend,
   input logic          commit
);
   // R7
   irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_in_o[HW-1] |-> (host_in_o[HW-2:0] != $past(host_in_o[HW-2:0])));

   // R6
   narrow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_rd_i |=> (host_in_o[HW-2:LO_W] == '0));

   // R8
   route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> (!$stable(lk_dst_i) || $stable(lk_src_o)));

   // R4
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !pend);

   // R2
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr_ld));
endmodule

bind gpio_strobe_port gpcp_checker #(
   .HW(LANE_W), .LO_W(LO_W), .IW(IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wide_rd_i (wide_rd_i),
   .host_in_o (host_in_o),
   .lk_dst_i  (lk_dst_i),
   .lk_src_o  (lk_src_o),
   .addr_ld   (addr_ld),
   .wr_en     (wr_en),
   .pend      (pend),
   .commit    (commit)
);

// File: tb/gpio_strobe_port_test.sv
module gpio_strobe_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] lane = 8'h00;
   logic       wide = 1'b1;
   logic [7:0] host_in;
   logic [7:0] lk_dst = 8'h00;
   logic [7:0] lk_src;

   int errors = 0;
   int checks = 0;
   int irq_cnt = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   gpio_strobe_port uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_i    (lane),
      .wide_rd_i (wide),
      .host_in_o (host_in),
      .lk_dst_i  (lk_dst),
      .lk_src_o  (lk_src)
   );

   always @(negedge clk) if (rst_n && host_in[7]) irq_cnt++;

   function automatic int fval(int i);
      return (i * 13 + 5) & 63;
   endfunction

   function automatic int sval(int d);
      return (d * 37 + 11) & 255;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic phase(input logic [6:0] c);
      @(negedge clk) lane = {1'b0, c};
      repeat (3) @(negedge clk);
      lane = {1'b1, c};
      repeat (5) @(negedge clk);
   endtask

   task automatic wr_reg(int r, int v);
      phase(7'(8'h40 | r));
      phase(7'(v & 63));
   endtask

   task automatic sel_reg(int r);
      phase(7'(8'h40 | r));
      repeat (2) @(negedge clk);
   endtask

   task automatic lookup(int d, output int s);
      @(negedge clk) lk_dst = 8'(d);
      #1 s = int'(lk_src);
   endtask

   task automatic set_link(int d, int s);
      wr_reg(48, d >> 5);
      wr_reg(49, d & 31);
      wr_reg(50, s >> 5);
      wr_reg(51, s & 31);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      summary();
   end

   initial begin
      int s, c0, e;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk("R1 host_in at reset", int'(host_in), 0);
      for (int d = 0; d < 256; d++) begin
         lookup(d, s);
         chk("R1 table entry at reset", s, 0);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4 data phase straight after reset: reg 0 must stay 0
      phase(7'h25);
      repeat (2) @(negedge clk);
      chk("R4 data without address", int'(host_in[6:0]), 0);
      sel_reg(0);
      chk("R4 reg0 still zero", int'(host_in[6:0]), 0);

      // R3 write after address phase
      wr_reg(0, 8'h11);
      repeat (2) @(negedge clk);
      chk("R3 write reg0", int'(host_in[6:0]), 8'h11);
      // R4 second data phase ignored
      phase(7'h22);
      repeat (2) @(negedge clk);
      chk("R4 second data ignored", int'(host_in[6:0]), 8'h11);

      // R5 lane change with strobe held high
      @(negedge clk) lane = 8'h80 | 8'h40;
      repeat (6) @(negedge clk);
      lane = 8'h80 | 8'h33;
      repeat (8) @(negedge clk);
      chk("R5 held strobe no write", int'(host_in[6:0]), 8'h11);
      // a proper edge now writes (address re-latched above only if edge seen)
      phase(7'h40);
      phase(7'h2A);
      repeat (2) @(negedge clk);
      chk("R3 write after edge", int'(host_in[6:0]), 8'h2A);

      // R2 / R3 sweep of all registers
      for (int r = 0; r < 64; r++) wr_reg(r, fval(r));
      for (int r = 0; r < 64; r++) begin
         sel_reg(r);
         if (r == 50) e = fval(50) & 7;
         else if (r == 51) e = fval(51) & 31;
         else e = fval(r);
         chk((r == 50 || r == 51) ? "R9 readback after sweep" : "R2 sweep readback",
             int'(host_in[6:0]), e);
      end
      // R8 commit from the sweep's write of reg 51
      lookup(((fval(48) & 7) << 5) | (fval(49) & 31), s);
      chk("R8 commit from sweep", s, ((fval(50) & 7) << 5) | (fval(51) & 31));

      // R6 narrow/wide masking
      wr_reg(20, 8'h3F);
      repeat (2) @(negedge clk);
      chk("R6 wide read", int'(host_in[6:0]), 8'h3F);
      wide = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 narrow read", int'(host_in[6:0]), 8'h1F);
      wide = 1'b1;
      repeat (3) @(negedge clk);

      // R7 interrupt pulses
      sel_reg(1);
      c0 = irq_cnt;
      sel_reg(2);
      chk("R7 one pulse on change", irq_cnt - c0, 1);
      wr_reg(10, fval(1));
      sel_reg(1);
      c0 = irq_cnt;
      sel_reg(10);
      chk("R7 no pulse same value", irq_cnt - c0, 0);

      // R8 / R11 full routing sweep
      for (int d = 0; d < 256; d++) set_link(d, sval(d));
      for (int d = 0; d < 256; d++) begin
         lookup(d, s);
         chk("R11 lookup after sweep", s, sval(d));
      end

      // R10 one source to many destinations, overwrite
      set_link(3, 9);
      set_link(200, 9);
      lookup(3, s);   chk("R10 dst3 src", s, 9);
      lookup(200, s); chk("R10 dst200 src", s, 9);
      lookup(4, s);   chk("R10 dst4 untouched", s, sval(4));
      set_link(3, 77);
      lookup(3, s);   chk("R10 dst3 overwritten", s, 77);
      lookup(200, s); chk("R10 dst200 kept", s, 9);

      // R8 oversize field bits are dropped
      wr_reg(48, 8'h3F);
      wr_reg(49, 8'h3F);
      wr_reg(50, 8'h3E);
      wr_reg(51, 8'h25);
      lookup(255, s);
      chk("R8 field masking", s, 6 * 32 + 5);

      // R9 readback through source registers
      wr_reg(48, 0);
      wr_reg(49, 3);
      sel_reg(50);
      chk("R9 src hi readback", int'(host_in[6:0]), 77 >> 5);
      sel_reg(51);
      chk("R9 src lo readback", int'(host_in[6:0]), 77 & 31);
      wr_reg(48, 130 >> 5);
      wr_reg(49, 130 & 31);
      sel_reg(50);
      chk("R9 src hi other dst", int'(host_in[6:0]), sval(130) >> 5);
      sel_reg(51);
      chk("R9 src lo other dst", int'(host_in[6:0]), sval(130) & 31);

      summary();
   end
endmodule